// File: doc/BRIEF.md
# Greedy Smallest-Free Color Selector

This block is the decision stage of an on-chip graph-coloring engine. The engine assigns every trellis stage of a parallel decoder to a memory bank so that stages used at the same time never share a bank. For each vertex, the surrounding logic reads the color tables twice. The first read returns the neighbours linked by first-phase edges. The second read returns the neighbours linked by second-phase edges. Each read delivers one word per table, and each word is a color plus a round bit.

The block keeps only the words whose round bit matches the current round flag and that are not marked as the vertex's own entry. It turns each kept color into a one-hot bit and merges the bits of both reads into one occupancy mask. It then picks the lowest color index that is absent from the mask. One cycle after the second read, it presents that color with a one-cycle write enable aimed at the table chosen by the caller. If every color is occupied, it raises an overflow pulse instead.

Because the round flag is inverted for each new configuration pass, entries left over from the previous pass read as uncolored. The tables therefore never need clearing.

Top module: `color_pick`

## Requirements
- R1: While reset is asserted and after its release, `sel_color` is 0, `sel_wen` is all zeros and `sel_ovf` is 0.
- R2: A read word takes part only if its round bit equals `round_flag`. A word with the other round bit has no effect on the chosen color.
- R3: A read word whose `rd_self` bit is 1 has no effect on the chosen color.
- R4: A read with `rd_second`=0 starts a new mask holding only its own valid colors and discards the earlier mask. A read with `rd_second`=1 merges its colors with that mask.
- R5: In the cycle after a read with `rd_second`=1, `sel_color` equals the lowest color index in 0..CMAX-1 that is absent from the merged mask.
- R6: In that same cycle, `sel_wen` has exactly bit `wr_tbl` set, where `wr_tbl` is the value sampled with the second read. `sel_wen` is all zeros in the following cycle unless another second read occurred.
- R7: If all CMAX colors are present in the merged mask, `sel_ovf` pulses for one cycle, `sel_wen` stays all zeros and `sel_color` keeps its previous value.
- R8: In the cycle after any clock edge without a second read, including after a first read alone, `sel_wen` is all zeros and `sel_ovf` is 0.
- R9: Used as a first-fit colorer over an 8-stage graph with 2 units, the written colors match a software first-fit model across two configuration rounds, and the second round ignores the first round's entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| round_flag | input | 1 | Current configuration round marker |
| rd_vld | input | 1 | A table read is presented this cycle |
| rd_second | input | 1 | 0 = first-phase-edge read, 1 = second-phase-edge read |
| rd_color | input | P*CW | Colors, word i at bits [i*CW +: CW] |
| rd_round | input | P | Round bit of each word |
| rd_self | input | P | Word is the vertex's own entry and is excluded |
| wr_tbl | input | TW | Table to receive the chosen color |
| sel_color | output | CW | Chosen color |
| sel_wen | output | P | One-hot write enable toward the tables |
| sel_ovf | output | 1 | All colors occupied |

## Verification
The assertions rely on a fixed input order: every read with `rd_second`=1 follows a read with `rd_second`=0 for the same vertex, and inputs are steady around each clock edge. The stimulus respects this order. The graph-coloring test always issues reads in pairs, and the directed tests pair them explicitly. Inputs are changed only just after a rising edge. The exception is the lone first read of R8, which is deliberately not followed by a second read.

// File: rtl/color_pick.sv
module color_pick #(
  parameter int P    = 2,
  parameter int CMAX = 4,
  localparam int CW  = (CMAX > 1) ? $clog2(CMAX) : 1,
  localparam int TW  = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            round_flag,
  input  logic            rd_vld,
  input  logic            rd_second,
  input  logic [P*CW-1:0] rd_color,
  input  logic [P-1:0]    rd_round,
  input  logic [P-1:0]    rd_self,
  input  logic [TW-1:0]   wr_tbl,
  output logic [CW-1:0]   sel_color,
  output logic [P-1:0]    sel_wen,
  output logic            sel_ovf
);

  logic [CMAX-1:0] acc_q, dec, full;
  logic [CW-1:0]   free_idx;
  logic            free_ok;

  always_comb begin
    dec = '0;
    for (int i = 0; i < P; i++)
      if (!rd_self[i] && rd_round[i] == round_flag &&
          int'(rd_color[i*CW +: CW]) < CMAX)
        dec[rd_color[i*CW +: CW]] = 1'b1;
  end

  assign full = acc_q | dec;

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int j = CMAX-1; j >= 0; j--)
      if (!full[j]) begin
        free_ok  = 1'b1;
        free_idx = CW'(j);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      sel_color <= '0;
      sel_wen   <= '0;
      sel_ovf   <= 1'b0;
    end else begin
      sel_wen <= '0;
      sel_ovf <= 1'b0;
      if (rd_vld) begin
        if (!rd_second) acc_q <= dec;
        else if (free_ok) begin
          sel_color <= free_idx;
          sel_wen   <= P'(1) << wr_tbl;
        end else sel_ovf <= 1'b1;
      end
    end
  end

  a_r6_wen_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_wen));

  a_r7_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ovf |-> sel_wen == '0);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_vld && rd_second) |=> (sel_wen == '0 && !sel_ovf));

  a_r5_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_second) |=> (sel_wen != '0 || sel_ovf));

  a_r6_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && rd_second) |=> (sel_ovf || sel_wen == (P'(1) << $past(wr_tbl))));

  a_r7_color_held: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ovf |-> $stable(sel_color));

endmodule

// File: tb/color_pick_tb.sv
module color_pick_tb_top;
  localparam int P = 2, CMAX = 4, CW = 2, TW = 1, L = 8;

  logic clk = 0, rst_n = 0, round_flag = 0, rd_vld = 0, rd_second = 0;
  logic [P*CW-1:0] rd_color = '0;
  logic [P-1:0] rd_round = '0, rd_self = '0;
  logic [TW-1:0] wr_tbl = '0;
  logic [CW-1:0] sel_color;
  logic [P-1:0] sel_wen;
  logic sel_ovf;

  int errors = 0, checks = 0;
  bit done = 0;

  color_pick #(.P(P), .CMAX(CMAX)) dut_i (.*);

  always #2.5 clk = ~clk;

  // behavioural reference, advanced on every rising edge
  int m_acc = 0, m_col = 0, m_wen = 0, m_ovf = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_col = 0; m_wen = 0; m_ovf = 0;
    end else begin
      automatic int msk = 0;
      m_wen = 0; m_ovf = 0;
      if (rd_vld) begin
        for (int i = 0; i < P; i++)
          if (!rd_self[i] && rd_round[i] == round_flag)
            msk |= 1 << rd_color[i*CW +: CW];
        if (!rd_second) m_acc = msk;
        else begin
          automatic int used = m_acc | msk;
          automatic int pick = -1;
          for (int c = CMAX-1; c >= 0; c--) if (!used[c]) pick = c;
          if (pick < 0) m_ovf = 1;
          else begin m_col = pick; m_wen = 1 << wr_tbl; end
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 color vs model", sel_color, m_col);
    chk("R6 wen vs model", sel_wen, m_wen);
    chk("R7 ovf vs model", sel_ovf, m_ovf);
  end

  task automatic rd(bit sec, int c0, bit t0, bit s0, int c1, bit t1, bit s1, int tbl);
    rd_vld = 1; rd_second = sec;
    rd_color = {CW'(c1), CW'(c0)};
    rd_round = {t1, t0}; rd_self = {s1, s0}; wr_tbl = TW'(tbl);
    @(posedge clk); #1;
    rd_vld = 0;
  endtask

  // graph model: 8 stages, 2 units, interleaver 5,3,7,8,1,4,6,2 (zero based)
  int pi_t[L] = '{4, 2, 6, 7, 0, 3, 5, 1};
  int tcol[L];
  bit ttag[L];

  function automatic int hi_partner(int s);
    int x = 0;
    for (int k = 0; k < L; k++) if (pi_t[k] == s) x = k;
    return pi_t[(x + L/2) % L];
  endfunction

  task automatic color_vertex(int v);
    int lo = (v + L/2) % L;
    int hi = hi_partner(v);
    int used = 0, exp = -1;
    if (ttag[lo] == round_flag) used |= 1 << tcol[lo];
    if (ttag[hi] == round_flag) used |= 1 << tcol[hi];
    for (int c = CMAX-1; c >= 0; c--) if (!used[c]) exp = c;
    rd(0, tcol[lo], ttag[lo], 0, tcol[v], ttag[v], 1, v / (L/P));
    rd(1, tcol[hi], ttag[hi], 0, tcol[v], ttag[v], 1, v / (L/P));
    chk("R9 first-fit color", sel_color, exp);
    chk("R9 write target", sel_wen, 1 << (v / (L/P)));
    if (sel_wen != 0) begin tcol[v] = sel_color; ttag[v] = round_flag; end
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    chk("R1 color at reset", sel_color, 0);
    chk("R1 wen at reset", sel_wen, 0);
    chk("R1 ovf at reset", sel_ovf, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 wen after release", sel_wen, 0);

    rd(0, 0, 1, 0, 0, 1, 0, 0);
    rd(1, 0, 1, 0, 0, 1, 0, 0);
    chk("R2 stale words ignored", sel_color, 0);
    rd(0, 0, 0, 0, 0, 0, 0, 0);
    rd(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 current word counts", sel_color, 1);

    rd(0, 0, 0, 1, 0, 0, 1, 0);
    rd(1, 1, 0, 1, 0, 0, 1, 0);
    chk("R3 self words excluded", sel_color, 0);

    rd(0, 0, 0, 0, 1, 0, 0, 0);
    rd(1, 2, 0, 0, 1, 0, 0, 1);
    chk("R4 two reads merged", sel_color, 3);
    chk("R6 target table 1", sel_wen, 2);
    @(posedge clk); #1;
    chk("R6 single pulse", sel_wen, 0);

    rd(0, 3, 0, 0, 3, 0, 0, 0);
    rd(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4 first read restarts mask", sel_color, 1);

    rd(0, 0, 0, 0, 1, 0, 0, 0);
    rd(1, 2, 0, 0, 3, 0, 0, 1);
    chk("R7 overflow flag", sel_ovf, 1);
    chk("R7 no write on overflow", sel_wen, 0);
    chk("R7 color held", sel_color, 1);

    rd(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 first read alone is quiet", sel_wen, 0);
    chk("R8 no overflow", sel_ovf, 0);

    for (int k = 0; k < 300; k++) begin
      rd(0, $urandom_range(3), 1'($urandom), 1'($urandom),
         $urandom_range(3), 1'($urandom), 1'($urandom), 0);
      rd(1, $urandom_range(3), 1'($urandom), 1'($urandom),
         $urandom_range(3), 1'($urandom), 1'($urandom), $urandom_range(1));
    end

    round_flag = 0;
    for (int v = 0; v < L; v++) begin tcol[v] = 0; ttag[v] = 1; end
    for (int v = 0; v < L; v++) color_vertex(v);
    round_flag = 1;
    for (int v = L-1; v >= 0; v--) color_vertex(v);

    @(posedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule